// File: doc/BRIEF.md
# PHY Power-Up Initialization Sequencer

After reset, a storage-card host PHY needs a fixed set of configuration steps before it can carry traffic. This block performs those steps in hardware. When `start` is pulsed it uses an indirect register bridge to reach the PHY registers. Most steps are read-modify-write: the block reads a register, ORs in a constant mask and writes the result back. The first group of steps powers the I/O pads and starts resistor-trim calibration. The block then polls a status register until the calibration-done flag appears. After that it enables the receivers, pull-ups and pad power on the command, strobe, data and clock lines, sets the clock buffer selection to its maximum, and writes the legacy mode code.

Every bridge access has its own time limit, and so does the calibration poll. Both limits are derived from the clock frequency and a timeout in microseconds. If an access stalls or calibration never completes, the sequence stops, the block drops its request and raises `error`. `error` stays high until the next `start`. A successful run ends with a single-cycle `done` pulse.

The bridge handshake works as follows. The block holds `br_req` high, with address, direction and write data stable, until the bridge returns a one-cycle `br_ack`. For reads, `br_rdata` is valid in the same cycle as `br_ack`.

Top module: `phy_init_seq`

## Requirements
- R1: After reset the block is idle: `br_req`, `done` and `error` are all low.
- R2: A `start` pulse begins the sequence. The block reads register 0x01 and writes it back ORed with 0x42 (bit 6 enables pad retention, bit 1 enables pad power). It then reads register 0x02 and writes it back ORed with 0x02 (bit 1 enables resistor-trim calibration).
- R3: The block then reads status register 0x03 repeatedly, one read per access, until bit 4 (calibration done) reads as 1. No other register is accessed before that.
- R4: Next come three read-modify-writes, in this order: 0x06 OR 0x03, 0x08 OR 0x02, 0x20 OR 0x01. These enable the receivers, pull-ups and pad power for the command and strobe lines.
- R5: Then five read-modify-writes, in this order: 0x07 OR 0xFF, 0x09 OR 0xFF, 0x21 OR 0xFF, 0x22 OR 0x01, 0x23 OR 0x01. These cover the data, strobe and clock lines.
- R6: Next comes a read-modify-write of 0x0F OR 0x07. Last, the block writes 0x04 to register 0x11 with no read of 0x11.
- R7: While `br_req` is high and `br_ack` has not arrived, `br_we`, `br_addr` and `br_wdata` stay stable. Each `br_ack` completes exactly one access.
- R8: If an access gets no `br_ack` within (CLK_FREQ_HZ/1e6)·TIMEOUT_US cycles, the block raises `error`, drops `br_req` and issues no further access.
- R9: The poll time limit starts when the poll step begins. If calibration is still not done after that many cycles, the block raises `error` and accesses nothing beyond register 0x03.
- R10: After the final write is acknowledged, `done` is high for exactly one cycle and `error` stays low.
- R11: `error` stays high until a `start` arrives. That `start` clears it and runs the sequence again from the first step.
- R12: A `start` that arrives while a sequence is running is ignored. The running sequence completes unchanged, with a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the sequence (honoured only while idle, done or in error) |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | Held high after an access or poll timeout until the next start |
| br_req | output | 1 | Bridge access request, held until acknowledged |
| br_we | output | 1 | 1 = write, 0 = read |
| br_addr | output | 8 | PHY register address |
| br_wdata | output | 8 | Write data |
| br_ack | input | 1 | One-cycle access completion from the bridge |
| br_rdata | input | 8 | Read data, valid with br_ack |

## Verification
A wrong step index or op decode shows up at once in the bridge transaction stream. A wrong address, a missing read before a write, or a wrong OR mask all appear within one or two accesses of the fault. The bench compares every transaction against a list it builds for itself, under several bridge latencies and calibration delays. A poll gate or timer that has gone wrong shows up differently: `error` fires too early or too late compared with the expected window of about 12,500 cycles, or accesses to register 0x06 appear before calibration is done. A state-machine fault near the end of the sequence shows up as a missing `done`, a repeated `done`, or an `error` that clears without a `start`.

// File: rtl/phy_init_pkg.sv
// Shared definitions for the PHY power-up sequencer: step encoding and the
// fixed ordered step list. Assumes 8-bit PHY addresses and data.
package phy_init_pkg;

    localparam int AW        = 8;
    localparam int DW        = 8;
    localparam int NUM_STEPS = 13;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    typedef enum logic [1:0] {
        OP_RMW   = 2'd0,   // read, OR in bits, write back
        OP_POLL  = 2'd1,   // read until (data & bits) != 0
        OP_WRITE = 2'd2    // write bits directly, no read
    } op_e;

    typedef struct packed {
        op_e           op;
        logic [AW-1:0] addr;
        logic [DW-1:0] bits;
    } step_t;

    // Ordered initialization steps; order is behaviour.
    function automatic step_t step_entry(input logic [STEP_W-1:0] idx);
        step_t s;
        case (idx)
            4'd0:    s = '{OP_RMW,   8'h01, 8'h42}; // pad power + retention
            4'd1:    s = '{OP_RMW,   8'h02, 8'h02}; // resistor trim enable
            4'd2:    s = '{OP_POLL,  8'h03, 8'h10}; // calibration done
            4'd3:    s = '{OP_RMW,   8'h06, 8'h03}; // cmd/strobe receivers
            4'd4:    s = '{OP_RMW,   8'h08, 8'h02}; // cmd pull-up
            4'd5:    s = '{OP_RMW,   8'h20, 8'h01}; // cmd pad power
            4'd6:    s = '{OP_RMW,   8'h07, 8'hFF}; // data receivers
            4'd7:    s = '{OP_RMW,   8'h09, 8'hFF}; // data pull-ups
            4'd8:    s = '{OP_RMW,   8'h21, 8'hFF}; // data pad power
            4'd9:    s = '{OP_RMW,   8'h22, 8'h01}; // strobe pad power
            4'd10:   s = '{OP_RMW,   8'h23, 8'h01}; // clock pad power
            4'd11:   s = '{OP_RMW,   8'h0F, 8'h07}; // max clock buffer
            default: s = '{OP_WRITE, 8'h11, 8'h04}; // legacy mode
        endcase
        return s;
    endfunction

endpackage

// File: rtl/phy_init_steps.sv
// Step table: decodes the current step index into op, address and bits.
// Assumes idx never exceeds NUM_STEPS-1; out-of-range maps to step 0.
module phy_init_steps
    import phy_init_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    output step_t             entry
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    step_t table_q [NUM_STEPS];

    // Build the constant table entry by entry.
    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_tab
        assign table_q[g] = step_entry(STEP_W'(g));
    end

    // Select the entry for the current step.
    always_comb entry = (idx <= LAST_STEP) ? table_q[idx] : table_q[0];

endmodule

// File: rtl/phy_init_timer.sv
// Saturating timeout counter. clr restarts it at zero, en advances it, and
// expired goes high once LIMIT cycles have been counted. Assumes LIMIT >= 1.
module phy_init_timer #(
    parameter int LIMIT = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int              CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0]   LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Count enabled cycles since the last clear, holding at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (clr)                    cnt_q <= '0;
        else if (en && cnt_q != LIM_V)   cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LIM_V);

    // R8/R9: the counter never runs past its limit
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_V);

    // R9: a clear always restarts the window
    a_r9_clr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !expired);

endmodule

// File: rtl/phy_init_ctrl.sv
// Sequencer FSM: walks the step list, issues bridge reads and writes, gates
// on the calibration poll and aborts to a held error on any timeout.
// Assumes the bridge acknowledges each held request with a one-cycle ack.
module phy_init_ctrl
    import phy_init_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ack,
    input  logic [DW-1:0]     rdata,
    input  logic              acc_exp,
    input  logic              poll_exp,
    input  step_t             entry,
    output logic [STEP_W-1:0] step_idx,
    output logic              acc_clr,
    output logic              acc_en,
    output logic              poll_clr,
    output logic              poll_en,
    output logic              req,
    output logic              we,
    output logic [AW-1:0]     addr,
    output logic [DW-1:0]     wdata,
    output logic              done,
    output logic              error
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_LAUNCH, ST_READ, ST_WRITE, ST_GAP, ST_DONE, ST_ERR
    } state_e;

    state_e            st_q, st_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [DW-1:0]     rd_q, rd_d;
    logic              hit;

    assign hit = (rdata & entry.bits) != '0;

    // Next-state, step advance and read capture.
    always_comb begin
        st_d     = st_q;
        step_d   = step_q;
        rd_d     = rd_q;
        acc_clr  = 1'b0;
        poll_clr = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_DONE, ST_ERR: begin
                if (start) begin
                    step_d = '0;
                    st_d   = ST_LAUNCH;
                end else if (st_q == ST_DONE) begin
                    st_d = ST_IDLE;
                end
            end
            ST_LAUNCH: begin
                acc_clr  = 1'b1;
                poll_clr = 1'b1;
                st_d     = (entry.op == OP_WRITE) ? ST_WRITE : ST_READ;
            end
            ST_READ: begin
                if (ack) begin
                    if (entry.op == OP_POLL) begin
                        if (hit) begin
                            if (step_q == LAST_STEP) st_d = ST_DONE;
                            else begin
                                step_d = step_q + 1'b1;
                                st_d   = ST_LAUNCH;
                            end
                        end else if (poll_exp) begin
                            st_d = ST_ERR;
                        end else begin
                            st_d = ST_GAP;
                        end
                    end else begin
                        rd_d    = rdata;
                        acc_clr = 1'b1;
                        st_d    = ST_WRITE;
                    end
                end else if (acc_exp) begin
                    st_d = ST_ERR;
                end
            end
            ST_WRITE: begin
                if (ack) begin
                    if (step_q == LAST_STEP) st_d = ST_DONE;
                    else begin
                        step_d = step_q + 1'b1;
                        st_d   = ST_LAUNCH;
                    end
                end else if (acc_exp) begin
                    st_d = ST_ERR;
                end
            end
            ST_GAP: begin
                acc_clr = 1'b1;
                st_d    = ST_READ;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, step and captured read data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
            rd_q   <= '0;
        end else begin
            st_q   <= st_d;
            step_q <= step_d;
            rd_q   <= rd_d;
        end
    end

    // Bridge request and status outputs decoded from state.
    always_comb begin
        req      = (st_q == ST_READ) || (st_q == ST_WRITE);
        we       = (st_q == ST_WRITE);
        addr     = entry.addr;
        wdata    = (entry.op == OP_RMW) ? (rd_q | entry.bits) : entry.bits;
        acc_en   = req;
        poll_en  = (entry.op == OP_POLL) && ((st_q == ST_READ) || (st_q == ST_GAP));
        done     = (st_q == ST_DONE);
        error    = (st_q == ST_ERR);
        step_idx = step_q;
    end

    // R7: a pending request holds its fields until acknowledged
    a_r7_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !acc_exp) |=> (req && $stable(addr) && $stable(we) && $stable(wdata)));

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done and error never together
    a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R11: error held until start
    a_r11_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    // R8: no bridge access while in error
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !req);

    // R6: the mode register is only ever written, never read
    a_r6_mode_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req && addr == 8'h11) |-> we);

    // R3: the poll step never writes
    a_r3_poll_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req && entry.op == OP_POLL) |-> !we);

endmodule

// File: rtl/phy_init_seq.sv
// Top of the PHY power-up sequencer: step table, two timeout counters (one
// per access, one per poll) and the sequencing FSM. Assumes CLK_FREQ_HZ is a
// whole number of MHz and the bridge answers each request with one ack.
module phy_init_seq
    import phy_init_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 125_000_000,
    parameter int TIMEOUT_US  = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          done,
    output logic          error,
    output logic          br_req,
    output logic          br_we,
    output logic [AW-1:0] br_addr,
    output logic [DW-1:0] br_wdata,
    input  logic          br_ack,
    input  logic [DW-1:0] br_rdata
);
    localparam int LIMIT = (CLK_FREQ_HZ / 1_000_000) * TIMEOUT_US;

    step_t             entry;
    logic [STEP_W-1:0] step_idx;
    logic              acc_clr, acc_en, acc_exp;
    logic              poll_clr, poll_en, poll_exp;

    phy_init_steps u_steps (
        .idx   (step_idx),
        .entry (entry)
    );

    phy_init_timer #(.LIMIT(LIMIT)) u_acc_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acc_clr),
        .en      (acc_en),
        .expired (acc_exp)
    );

    phy_init_timer #(.LIMIT(LIMIT)) u_poll_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (poll_clr),
        .en      (poll_en),
        .expired (poll_exp)
    );

    phy_init_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ack      (br_ack),
        .rdata    (br_rdata),
        .acc_exp  (acc_exp),
        .poll_exp (poll_exp),
        .entry    (entry),
        .step_idx (step_idx),
        .acc_clr  (acc_clr),
        .acc_en   (acc_en),
        .poll_clr (poll_clr),
        .poll_en  (poll_en),
        .req      (br_req),
        .we       (br_we),
        .addr     (br_addr),
        .wdata    (br_wdata),
        .done     (done),
        .error    (error)
    );

endmodule

// File: tb/phy_init_seq_tb.sv
module phy_init_seq_tb;
    localparam int CLK_HZ  = 125_000_000;
    localparam int TOUT_US = 100;
    localparam int LIMIT   = (CLK_HZ / 1_000_000) * TOUT_US;

    // Scenario table: {latency, cal reads, seed, stall index (FF = none)}
    localparam logic [31:0] VEC [5] = '{
        {8'd0, 8'd1, 8'h11, 8'hFF},
        {8'd1, 8'd3, 8'h2C, 8'hFF},
        {8'd3, 8'd5, 8'hC3, 8'hFF},
        {8'd2, 8'd2, 8'h00, 8'hFF},
        {8'd0, 8'd1, 8'h77, 8'd7}
    };

    // Bench copy of the RMW order from R2, R4, R5, R6
    localparam logic [7:0] RA [11] = '{8'h01,8'h02,8'h06,8'h08,8'h20,8'h07,8'h09,8'h21,8'h22,8'h23,8'h0F};
    localparam logic [7:0] RM [11] = '{8'h42,8'h02,8'h03,8'h02,8'h01,8'hFF,8'hFF,8'hFF,8'h01,8'h01,8'h07};

    logic clk = 0, rst_n = 0, start = 0;
    logic done, error, br_req, br_we, br_ack;
    logic [7:0] br_addr, br_wdata, br_rdata;

    always #4 clk = ~clk;

    phy_init_seq #(.CLK_FREQ_HZ(CLK_HZ), .TIMEOUT_US(TOUT_US)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
        .br_req(br_req), .br_we(br_we), .br_addr(br_addr), .br_wdata(br_wdata),
        .br_ack(br_ack), .br_rdata(br_rdata)
    );

    int tests = 0, fails = 0;

    // bridge model configuration
    int lat_cfg = 0, cal_cfg = 1, stall_at = -1;
    logic [7:0] seed_cfg = 8'h00;
    logic log_clr = 0;

    logic [7:0] mem [256];
    int wait_cnt, tr_n, oth_n, rd3_cnt, done_cnt;
    logic       tr_we   [64];
    logic [7:0] tr_addr [64];
    logic [7:0] tr_data [64];

    logic       ex_we   [64];
    logic [7:0] ex_addr [64];
    logic [7:0] ex_data [64];
    int ex_n;

    function automatic logic [7:0] init_val(input logic [7:0] a, input logic [7:0] s);
        return (a * 8'h1D) ^ s ^ 8'hA5;
    endfunction

    // Bridge model: acks each request after lat_cfg wait cycles, logs it.
    always @(posedge clk) begin
        if (done) done_cnt <= done_cnt + 1;
        br_ack <= 1'b0;
        if (log_clr) begin
            for (int a = 0; a < 256; a++) mem[a] <= init_val(8'(a), seed_cfg);
            wait_cnt <= 0; tr_n <= 0; oth_n <= 0; rd3_cnt <= 0; done_cnt <= 0;
        end else if (br_req && !br_ack && tr_n != stall_at) begin
            if (wait_cnt >= lat_cfg) begin
                br_ack   <= 1'b1;
                wait_cnt <= 0;
                if (tr_n < 64) begin
                    tr_we[tr_n]   <= br_we;
                    tr_addr[tr_n] <= br_addr;
                    tr_data[tr_n] <= br_wdata;
                end
                tr_n <= tr_n + 1;
                if (br_addr != 8'h03) oth_n <= oth_n + 1;
                if (br_we) mem[br_addr] <= br_wdata;
                if (br_addr == 8'h03) begin
                    br_rdata <= (mem[3] & 8'hEF) | ((rd3_cnt + 1 >= cal_cfg) ? 8'h10 : 8'h00);
                    rd3_cnt  <= rd3_cnt + 1;
                end else begin
                    br_rdata <= mem[br_addr];
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic w, input logic [7:0] a, input logic [7:0] d);
        ex_we[ex_n] = w; ex_addr[ex_n] = a; ex_data[ex_n] = d; ex_n++;
    endtask

    // Expected transaction list from R2..R6
    task automatic build_exp(input int cal, input logic [7:0] s);
        ex_n = 0;
        for (int j = 0; j < 11; j++) begin
            if (j == 2) for (int k = 0; k < cal; k++) push(1'b0, 8'h03, 8'h00);
            push(1'b0, RA[j], 8'h00);
            push(1'b1, RA[j], init_val(RA[j], s) | RM[j]);
        end
        push(1'b1, 8'h11, 8'h04);
    endtask

    task automatic setup(input int lat, input int cal, input logic [7:0] s, input int stall);
        @(negedge clk);
        lat_cfg = lat; cal_cfg = cal; seed_cfg = s; stall_at = stall; log_clr = 1;
        @(negedge clk);
        log_clr = 0;
    endtask

    task automatic pulse_start;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_end(input int maxc, output int el);
        el = 1;
        while (!done && !error && el < maxc) begin
            @(negedge clk); el++;
        end
    endtask

    task automatic compare_seq(input int cal);
        string tag;
        for (int i = 0; i < ex_n; i++) begin
            if (i < 4) tag = "R2";
            else if (i < 4 + cal) tag = "R3";
            else if (i < 10 + cal) tag = "R4";
            else if (i < 20 + cal) tag = "R5";
            else tag = "R6";
            check(tr_we[i] == ex_we[i] && tr_addr[i] == ex_addr[i] &&
                  (!ex_we[i] || tr_data[i] == ex_data[i]), tag,
                  {tr_we[i], tr_addr[i], tr_data[i]}, {ex_we[i], ex_addr[i], ex_data[i]});
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (199000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 199000, 0);
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        int el, cal, stall;
        setup(0, 1, 8'h00, -1);
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle after reset
        check(!br_req && !done && !error, "R1", {br_req, done, error}, 0);

        // Table walk
        for (int v = 0; v < 5; v++) begin
            cal   = int'(VEC[v][23:16]);
            stall = (VEC[v][7:0] == 8'hFF) ? -1 : int'(VEC[v][7:0]);
            setup(int'(VEC[v][31:24]), cal, VEC[v][15:8], stall);
            build_exp(cal, VEC[v][15:8]);
            pulse_start;
            wait_end(LIMIT + 300, el);
            repeat (3) @(negedge clk);
            if (stall < 0) begin
                check(done_cnt == 1 && !error, "R10", done_cnt, 1);
                check(tr_n == ex_n, "R6", tr_n, ex_n);
                compare_seq(cal);
                check(!done && !br_req, "R10", {done, br_req}, 0);
            end else begin
                check(error && done_cnt == 0, "R8", {error, 8'(done_cnt)}, 9'h100);
                check(tr_n == stall && !br_req, "R8", tr_n, stall);
                check(el >= LIMIT && el <= LIMIT + 40, "R8", el, LIMIT);
            end
        end

        // R8: stall on the very first access
        setup(0, 1, 8'h33, 0);
        pulse_start;
        wait_end(LIMIT + 300, el);
        check(error && el >= LIMIT && el <= LIMIT + 20, "R8", el, LIMIT);
        @(negedge clk);
        check(tr_n == 0 && !br_req, "R8", tr_n, 0);

        // R11: error holds with no start
        repeat (20) @(negedge clk);
        check(error, "R11", error, 1);

        // R9: calibration never completes
        setup(0, 1000000, 8'h5E, -1);
        pulse_start;
        check(!error, "R11", error, 0);
        wait_end(LIMIT + 400, el);
        check(error && el >= LIMIT && el <= LIMIT + 120, "R9", el, LIMIT);
        repeat (3) @(negedge clk);
        check(oth_n == 4 && !br_req && done_cnt == 0, "R9", oth_n, 4);

        // R11: start from error reruns the sequence
        setup(1, 2, 8'h9A, -1);
        build_exp(2, 8'h9A);
        pulse_start;
        check(!error, "R11", error, 0);
        wait_end(2000, el);
        repeat (3) @(negedge clk);
        check(done_cnt == 1 && tr_n == ex_n, "R11", tr_n, ex_n);
        compare_seq(2);

        // R12: start during a running sequence is ignored
        setup(2, 3, 8'h4B, -1);
        build_exp(3, 8'h4B);
        pulse_start;
        repeat (10) @(negedge clk);
        pulse_start;
        repeat (15) @(negedge clk);
        pulse_start;
        wait_end(2000, el);
        repeat (3) @(negedge clk);
        check(done_cnt == 1 && tr_n == ex_n && !error, "R12", tr_n, ex_n);
        compare_seq(3);

        // R7: long latency keeps fields stable
        setup(3, 1, 8'hE1, -1);
        build_exp(1, 8'hE1);
        pulse_start;
        wait_end(2000, el);
        repeat (3) @(negedge clk);
        check(done_cnt == 1 && tr_n == ex_n, "R7", tr_n, ex_n);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule